// File: doc/BRIEF.md
# CEC Transmit Message Sequencer

This block orders the bytes of one outgoing consumer-electronics-control message for a bit-level transmitter. It forms the first byte of the frame from the sender's own logical address and the target's logical address, then fetches each following byte from a host through a request/offer handshake. It tags the final byte so that the transmitter can signal end of message. Bit timing, line driving and acknowledge sampling belong to the bit engine downstream. The engine returns one status pulse per finished byte.

A message starts with a one-cycle start command. A one-cycle end command, given together with a host byte or while that byte is pending, marks that byte as the final one. For a frame that has only the header byte (a ping), the end command must be given before the start command. The sequencer has one staging register, so the host has the whole transmission time of the current byte to offer the next one. Six sticky event flags, each with its own interrupt enable, report the outcome of the message.

Top module: `cec_tx_sequencer`

## Requirements
- R1: On a start command while idle, the first byte handed to the engine (`eng_load` high one cycle after the command) is `{init_addr, dst_addr}`, with the initiator in bits 7:4 and the destination in bits 3:0. `busy` rises in the same cycle.
- R2: If the end command was given before the start command, or in the same cycle as it, the header is the only byte. It carries `eng_last`=1, no byte request is raised, and flag bit 1 stays clear.
- R3: Each time a non-final byte is handed to the engine, `byte_req` rises in the same cycle and flag bit 1 (byte request) is set. A host byte offered while `byte_req` is high is taken and clears `byte_req` on the next cycle, unless that byte is handed on at once (R7).
- R4: The host byte accepted together with, or after, a pending end command is handed on with `eng_last`=1. The 15th payload byte is always marked last, whether or not an end command came with it. No byte before the last one carries `eng_last`.
- R5: When the engine reports a byte marked last as done, with no fault, flag bit 0 (transmit end) is set and `busy` falls.
- R6: When the engine finishes a non-final byte while no next byte is staged and none is offered in that cycle, flag bit 2 (underrun) is set, no further byte is loaded and `busy` falls.
- R7: A host byte offered in the same cycle as the engine's done pulse for a non-final byte, with nothing staged, is handed to the engine on the next cycle and causes no underrun.
- R8: A done pulse with arbitration loss sets flag bit 4 only, never flag bit 0, and returns the block to idle. Arbitration loss takes priority over a transmit error and over a missing acknowledge reported in the same pulse.
- R9: A done pulse with transmit error (flag bit 5) or missing acknowledge (flag bit 3) ends the message without setting flag bit 0. A transmit error takes priority over a missing acknowledge.
- R10: Flags stay set until cleared by a one on the matching bit of `flag_clr`. When a set and a clear hit the same flag in the same cycle, the set wins.
- R11: `irq` is high exactly when some bit of `flags` and the matching bit of `irq_en` are both high.
- R12: A start command while `busy` is high is ignored: no byte is added to the message and no second message follows.
- R13: After reset, `busy`, `byte_req`, `eng_load`, `flags` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| init_addr | input | 4 | Own logical address, sampled at start |
| dst_addr | input | 4 | Destination logical address, sampled at start |
| cmd_start | input | 1 | Start-of-message command pulse |
| cmd_end | input | 1 | End-of-message command pulse |
| host_data | input | 8 | Next payload byte from the host |
| host_valid | input | 1 | Host offers `host_data` this cycle |
| byte_req | output | 1 | Sequencer waits for the next payload byte |
| eng_load | output | 1 | Pulse: `eng_byte` is handed to the bit engine |
| eng_byte | output | 8 | Byte being transmitted |
| eng_last | output | 1 | Byte being transmitted is the final one |
| eng_done | input | 1 | Engine finished the current byte |
| eng_nack | input | 1 | With `eng_done`: acknowledge missing |
| eng_arb | input | 1 | With `eng_done`: arbitration lost |
| eng_err | input | 1 | With `eng_done`: transmit error |
| busy | output | 1 | A message is in progress |
| flag_clr | input | 6 | Write-one-to-clear for the flags |
| irq_en | input | 6 | Per-flag interrupt enable |
| flags | output | 6 | Bit0 end, bit1 byte request, bit2 underrun, bit3 no-ack, bit4 arbitration lost, bit5 error |
| irq | output | 1 | OR of enabled flags |

## Verification
The critical collision is the host's offer of byte k+1 landing in the same cycle as the engine's done pulse for byte k with the staging register empty. The bench provokes it by setting the host reply delay equal to the modelled byte time. With that delay every payload byte of a message takes the bypass path. Correct delivery of all bytes, with the underrun flag clear, is the verdict. One cycle more of delay must instead yield an underrun after the header. A second collision, a flag set and its clear in the same cycle, is provoked by pulsing the clear of the end flag together with the final done pulse. That flag must read one afterwards.

// File: rtl/cec_seq_pkg.sv
// Shared constants of the transmit sequencer: flag bit positions and width.
// Assumes: positions are visible to software and to the bench, so they are fixed.
package cec_seq_pkg;
    localparam int FLAG_N = 6;
    localparam int F_END  = 0;   // last byte sent with acknowledge
    localparam int F_BREQ = 1;   // next byte requested from host
    localparam int F_UDR  = 2;   // host failed to supply a byte in time
    localparam int F_NACK = 3;   // acknowledge missing
    localparam int F_ARB  = 4;   // arbitration lost
    localparam int F_ERR  = 5;   // generic transmit error
    typedef logic [FLAG_N-1:0] flag_vec_t;
endpackage

// File: rtl/cec_seq_stage.sv
// One-entry staging register between the host offer and the bit engine.
// Assumes: the controller never pushes while full and never pushes and pops together.
module cec_seq_stage #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_data,
    input  logic              push_last,
    input  logic              pop,
    input  logic              flush,
    output logic              valid,
    output logic [BYTE_W-1:0] data,
    output logic              last
);
    logic              valid_q;
    logic [BYTE_W-1:0] data_q;
    logic              last_q;

    // Holds one pending byte and its final-byte tag until the engine takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
            last_q  <= 1'b0;
        end else if (flush || pop) begin
            valid_q <= 1'b0;
        end else if (push) begin
            valid_q <= 1'b1;
            data_q  <= push_data;
            last_q  <= push_last;
        end
    end

    assign valid = valid_q;
    assign data  = data_q;
    assign last  = last_q;

    // R7: the single entry is never overwritten
    a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !valid_q);
    // R3: a pop only happens with a staged byte
    a_r3_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> valid_q);
endmodule

// File: rtl/cec_seq_ctrl.sv
// Message controller: launches the header, requests and forwards payload,
// tags the last byte and ends the message on completion or fault.
// Assumes: eng_done is a one-cycle pulse per loaded byte, status valid with it.
module cec_seq_ctrl
    import cec_seq_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int MAX_PAYLOAD = 15,
    localparam int BYTE_W     = 2 * ADDR_W,
    localparam int CNT_W      = $clog2(MAX_PAYLOAD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] init_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic              cmd_start,
    input  logic              cmd_end,
    input  logic [BYTE_W-1:0] host_data,
    input  logic              host_valid,
    output logic              byte_req,
    output logic              eng_load,
    output logic [BYTE_W-1:0] eng_byte,
    output logic              eng_last,
    input  logic              eng_done,
    input  logic              eng_nack,
    input  logic              eng_arb,
    input  logic              eng_err,
    output logic              busy,
    input  logic              stg_valid,
    input  logic [BYTE_W-1:0] stg_data,
    input  logic              stg_last,
    output logic              stg_push,
    output logic              stg_push_last,
    output logic              stg_pop,
    output logic              stg_flush,
    output flag_vec_t         events
);
    logic              busy_q, req_q, end_armed_q, cur_last_q, load_q;
    logic [BYTE_W-1:0] byte_q;
    logic [CNT_W-1:0]  pay_cnt_q;

    logic end_now, host_last, take_host, launch;
    logic done_v, fault, done_ok, advance, finish, bypass, underrun;
    logic arb_hit, err_hit, nack_hit;
    logic load_now, load_last, req_d, stop;
    logic [BYTE_W-1:0] load_byte;

    // Decodes the command, host and engine inputs into this cycle's actions.
    always_comb begin
        end_now   = end_armed_q || cmd_end;
        host_last = end_now || (pay_cnt_q == CNT_W'(MAX_PAYLOAD - 1));
        take_host = req_q && host_valid;
        launch    = !busy_q && cmd_start;
        done_v    = busy_q && eng_done;
        arb_hit   = done_v && eng_arb;
        err_hit   = done_v && !eng_arb && eng_err;
        nack_hit  = done_v && !eng_arb && !eng_err && eng_nack;
        fault     = arb_hit || err_hit || nack_hit;
        done_ok   = done_v && !fault;
        advance   = done_ok && !cur_last_q;
        finish    = done_ok && cur_last_q;
        bypass    = advance && !stg_valid && take_host;
        underrun  = advance && !stg_valid && !take_host;
        stop      = fault || underrun || finish;
    end

    // Selects the byte handed to the engine and the next request state.
    always_comb begin
        load_now  = 1'b0;
        load_byte = stg_data;
        load_last = stg_last;
        req_d     = req_q;
        if (launch) begin
            load_now  = 1'b1;
            load_byte = {init_addr, dst_addr};
            load_last = end_now;
            req_d     = !end_now;
        end else if (stop) begin
            req_d = 1'b0;
        end else if (advance && stg_valid) begin
            load_now = 1'b1;
            req_d    = !stg_last;
        end else if (bypass) begin
            load_now  = 1'b1;
            load_byte = host_data;
            load_last = host_last;
            req_d     = !host_last;
        end else if (take_host) begin
            req_d = 1'b0;
        end
    end

    assign stg_push      = take_host && !bypass && !stop;
    assign stg_push_last = host_last;
    assign stg_pop       = advance && stg_valid;
    assign stg_flush     = stop;

    // Reports one pulse per event to the flag bank.
    always_comb begin
        events         = '0;
        events[F_END]  = finish;
        events[F_BREQ] = load_now && !load_last;
        events[F_UDR]  = underrun;
        events[F_NACK] = nack_hit;
        events[F_ARB]  = arb_hit;
        events[F_ERR]  = err_hit;
    end

    // Holds message state: activity, request, end arming, payload count, engine byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            req_q       <= 1'b0;
            end_armed_q <= 1'b0;
            cur_last_q  <= 1'b0;
            load_q      <= 1'b0;
            byte_q      <= '0;
            pay_cnt_q   <= '0;
        end else begin
            load_q <= load_now;
            req_q  <= req_d;
            if (load_now) begin
                byte_q     <= load_byte;
                cur_last_q <= load_last;
            end
            if (launch)    busy_q <= 1'b1;
            else if (stop) busy_q <= 1'b0;
            if (launch)         pay_cnt_q <= '0;
            else if (take_host) pay_cnt_q <= pay_cnt_q + 1'b1;
            if (launch || take_host || fault || underrun) end_armed_q <= 1'b0;
            else if (cmd_end)                             end_armed_q <= 1'b1;
        end
    end

    assign busy     = busy_q;
    assign byte_req = req_q;
    assign eng_load = load_q;
    assign eng_byte = byte_q;
    assign eng_last = cur_last_q;

    // R1: a new message always begins with a byte hand-over
    a_r1_header_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> load_q);
    // R3: a request exists only inside a message
    a_r3_req_in_msg: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> busy_q);
    // R4: once the final byte is handed over, nothing more is requested
    a_r4_last_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (load_q && cur_last_q) |-> !req_q);
    // R8: arbitration loss returns to idle with no further byte
    a_r8_arb_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && eng_done && eng_arb) |=> (!busy_q && !load_q));
    // R6: underrun stops loading
    a_r6_udr_stops: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> (!busy_q && !load_q));
    // R12: no hand-over without an active message
    a_r12_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        load_q |-> busy_q);
endmodule

// File: rtl/cec_seq_flags.sv
// Sticky event flags with write-one-to-clear and a masked interrupt.
// Assumes: a set pulse beats a clear on the same bit in the same cycle.
module cec_seq_flags
    import cec_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_vec_t set,
    input  flag_vec_t clr,
    input  flag_vec_t en,
    output flag_vec_t flags,
    output logic      irq
);
    flag_vec_t flags_q;

    // Accumulates event pulses; clears by write-one unless a new event arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr) | set;
    end

    assign flags = flags_q;
    assign irq   = |(flags_q & en);

    // R10: every set pulse is visible the next cycle
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((flags_q & $past(set)) == $past(set)));
    // R10: flags not cleared persist
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_q & ~clr) != '0) |=> ((flags_q & $past(flags_q & ~clr)) == $past(flags_q & ~clr)));
endmodule

// File: rtl/cec_tx_sequencer.sv
// Top of the transmit message sequencer: controller, staging register and flags.
// Assumes: the bit engine accepts a byte on eng_load and pulses eng_done once per byte.
module cec_tx_sequencer
    import cec_seq_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int MAX_PAYLOAD = 15,
    localparam int BYTE_W     = 2 * ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] init_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic              cmd_start,
    input  logic              cmd_end,
    input  logic [BYTE_W-1:0] host_data,
    input  logic              host_valid,
    output logic              byte_req,
    output logic              eng_load,
    output logic [BYTE_W-1:0] eng_byte,
    output logic              eng_last,
    input  logic              eng_done,
    input  logic              eng_nack,
    input  logic              eng_arb,
    input  logic              eng_err,
    output logic              busy,
    input  logic [FLAG_N-1:0] flag_clr,
    input  logic [FLAG_N-1:0] irq_en,
    output logic [FLAG_N-1:0] flags,
    output logic              irq
);
    logic              stg_valid, stg_last, stg_push, stg_push_last, stg_pop, stg_flush;
    logic [BYTE_W-1:0] stg_data;
    flag_vec_t         events;

    cec_seq_ctrl #(.ADDR_W(ADDR_W), .MAX_PAYLOAD(MAX_PAYLOAD)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .init_addr(init_addr), .dst_addr(dst_addr),
        .cmd_start(cmd_start), .cmd_end(cmd_end),
        .host_data(host_data), .host_valid(host_valid), .byte_req(byte_req),
        .eng_load(eng_load), .eng_byte(eng_byte), .eng_last(eng_last),
        .eng_done(eng_done), .eng_nack(eng_nack), .eng_arb(eng_arb), .eng_err(eng_err),
        .busy(busy),
        .stg_valid(stg_valid), .stg_data(stg_data), .stg_last(stg_last),
        .stg_push(stg_push), .stg_push_last(stg_push_last),
        .stg_pop(stg_pop), .stg_flush(stg_flush),
        .events(events)
    );

    cec_seq_stage #(.BYTE_W(BYTE_W)) u_stage (
        .clk(clk), .rst_n(rst_n),
        .push(stg_push), .push_data(host_data), .push_last(stg_push_last),
        .pop(stg_pop), .flush(stg_flush),
        .valid(stg_valid), .data(stg_data), .last(stg_last)
    );

    cec_seq_flags u_flags (
        .clk(clk), .rst_n(rst_n),
        .set(events), .clr(flag_clr), .en(irq_en),
        .flags(flags), .irq(irq)
    );
endmodule

// File: tb/test_cec_tx_sequencer.sv
// Bench: models the host and a bit engine with a fixed byte time, sweeps
// payload lengths and reply delays, and injects faults.
module test_cec_tx_sequencer;
    localparam int T  = 12;   // modelled byte time in cycles
    localparam int FN = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] init_addr = '0, dst_addr = '0;
    logic       cmd_start = 0, cmd_end = 0, host_valid = 0;
    logic [7:0] host_data = '0;
    logic       byte_req, eng_load, eng_last, busy, irq;
    logic [7:0] eng_byte;
    logic       eng_done = 0, eng_nack = 0, eng_arb = 0, eng_err = 0;
    logic [FN-1:0] flag_clr = '0, irq_en = '0, flags;

    always #2 clk = ~clk;

    cec_tx_sequencer i_cec_tx_sequencer (
        .clk(clk), .rst_n(rst_n), .init_addr(init_addr), .dst_addr(dst_addr),
        .cmd_start(cmd_start), .cmd_end(cmd_end), .host_data(host_data),
        .host_valid(host_valid), .byte_req(byte_req), .eng_load(eng_load),
        .eng_byte(eng_byte), .eng_last(eng_last), .eng_done(eng_done),
        .eng_nack(eng_nack), .eng_arb(eng_arb), .eng_err(eng_err), .busy(busy),
        .flag_clr(flag_clr), .irq_en(irq_en), .flags(flags), .irq(irq)
    );

    int checks = 0, errors = 0;
    logic [7:0] sent [0:31];
    logic       slast [0:31];
    int nsent, ecnt, hcnt, hk, cyc;
    int m_n, m_dly, m_fidx; logic m_end, m_xstart, m_clrfin; logic [2:0] m_fk;

    function automatic logic [7:0] pat(int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    task automatic chk(bit ok, string rq, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // One cycle of the host and engine models, driven at the falling edge.
    task automatic step();
        @(negedge clk);
        cyc++;
        eng_done = 0; eng_nack = 0; eng_arb = 0; eng_err = 0;
        host_valid = 0; cmd_end = 0; cmd_start = 0; flag_clr = '0;
        if (eng_load) begin
            if (nsent < 32) begin sent[nsent] = eng_byte; slast[nsent] = eng_last; end
            nsent++; ecnt = T;
        end else if (ecnt > 0) begin
            ecnt--;
            if (ecnt == 1) begin
                eng_done = 1; ecnt = 0;
                if (nsent - 1 == m_fidx) {eng_err, eng_arb, eng_nack} = m_fk;
                if (m_clrfin && nsent - 1 == m_n) flag_clr = 6'b000001;
            end
        end
        if (byte_req) begin
            hcnt++;
            if (hcnt >= m_dly) begin
                host_valid = 1; host_data = pat(hk);
                cmd_end = m_end && (hk == m_n);
                hk++; hcnt = 0;
            end
        end else hcnt = 0;
        if (m_xstart && cyc == 3) cmd_start = 1;
    endtask

    task automatic run_msg(int n, bit use_end, int dly, int fidx, logic [2:0] fk,
                           bit xstart, bit clrfin, logic [FN-1:0] en);
        int ab, cnt, bad, badl, lim; bit udr, seen;
        logic [FN-1:0] ef;
        m_n = n; m_end = use_end; m_dly = dly; m_fidx = fidx; m_fk = fk;
        m_xstart = xstart; m_clrfin = clrfin;
        nsent = 0; ecnt = 0; hcnt = 0; hk = 1; cyc = 0;
        init_addr = 4'((n + 5) & 15); dst_addr = 4'(n & 15); irq_en = en;
        @(negedge clk);
        if (n == 0) begin cmd_end = 1; @(negedge clk); cmd_end = 0; end
        cmd_start = 1;
        seen = 0; lim = 0;
        while (lim < 2000) begin
            step(); lim++;
            if (busy) seen = 1;
            else if (seen) break;
        end
        chk(lim < 2000, "R5 message ends", lim, 0);
        ab  = (fidx >= 0 && fidx <= n) ? fidx : -1;
        udr = (ab != 0) && n >= 1 && dly > T;
        if (ab == 0 || udr) cnt = 1; else if (ab > 0) cnt = ab + 1; else cnt = n + 1;
        ef = '0;
        ef[0] = !udr && ab < 0;
        ef[1] = n >= 1;
        ef[2] = udr;
        if (ab >= 0 && !udr) begin
            if (fk[1]) ef[4] = 1; else if (fk[2]) ef[5] = 1; else if (fk[0]) ef[3] = 1;
        end
        chk(nsent == cnt, "R6/R8 byte count", nsent, cnt);
        chk(sent[0] == {init_addr, dst_addr}, "R1 header", sent[0], {init_addr, dst_addr});
        bad = 0; badl = 0;
        for (int i = 1; i < cnt && i < 32; i++) if (sent[i] != pat(i)) bad++;
        for (int i = 0; i < cnt && i < 32; i++) if (slast[i] != (i == n)) badl++;
        chk(bad == 0, "R3/R7 payload bytes", bad, 0);
        chk(badl == 0, "R2/R4 last marker", badl, 0);
        chk(flags == ef, "R5/R6/R8/R9/R10 flags", flags, ef);
        chk(irq == |(ef & en), "R11 irq", irq, |(ef & en));
        chk(byte_req == 0, "R3 request idle", byte_req, 0);
        step(); flag_clr = '1; step();
        chk(flags == 0, "R10 clear", flags, 0);
        cnt = nsent;
        for (int i = 0; i < 15; i++) step();
        chk(nsent == cnt && !busy, "R12 no extra message", nsent, cnt);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_n = 0; m_dly = 1; m_fidx = -1; m_fk = 0; m_end = 0; m_xstart = 0; m_clrfin = 0;
        nsent = 0; ecnt = 0; hcnt = 0; hk = 1; cyc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !byte_req && !eng_load && flags == 0 && !irq, "R13 reset state",
            {busy, byte_req, eng_load, irq}, 0);
        // R2/R3/R4/R7: all lengths, early reply and same-cycle reply; n=15 early without end (cap)
        for (int n = 0; n <= 15; n++) begin
            run_msg(n, !(n == 15), 1, -1, 3'b000, 0, 0, 6'(1 << (n % 6)));
            run_msg(n, 1, T, -1, 3'b000, 0, 0, 6'b111111);
        end
        // R6: late host
        run_msg(1, 1, T + 1, -1, 3'b000, 0, 0, 6'b000100);
        run_msg(3, 1, T + 1, -1, 3'b000, 0, 0, 6'b000000);
        run_msg(7, 1, T + 4, -1, 3'b000, 0, 0, 6'b111011);
        // R8: arbitration at header, with and without payload, and priority
        run_msg(4, 1, 1, 0, 3'b010, 0, 0, 6'b010000);
        run_msg(0, 1, 1, 0, 3'b010, 0, 0, 6'b000001);
        run_msg(6, 1, 2, 3, 3'b111, 0, 0, 6'b110000);
        // R9: missing ack and error
        run_msg(5, 1, 3, 2, 3'b001, 0, 0, 6'b001000);
        run_msg(3, 1, 1, 1, 3'b101, 0, 0, 6'b100000);
        // R12: start while busy; R10: clear collides with end event
        run_msg(3, 1, 1, -1, 3'b000, 1, 0, 6'b000000);
        run_msg(2, 1, 1, -1, 3'b000, 0, 1, 6'b000001);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule